// File: doc/BRIEF.md
# Histogram Accumulator with Increment

This block keeps a histogram of the values presented to it. It holds 2^M bins, each an N-bit count, in an internal memory. Every clock cycle it takes one command, picked by a single control bit. A write command adds one to the bin that the M-bit input value selects. A read command returns that bin's count on an N-bit output one cycle later, with a valid flag.

Each write is a fetch, an add and a store of one memory word. The work is split over two pipeline stages, so the block still accepts a command every cycle. A write whose result has not yet reached memory is forwarded to a following command for the same bin. Because of this, back-to-back hits on one bin are all counted, and a read placed right after a write sees the new count. A count that reaches its largest value stays there.

A clear request, and also reset, starts a sweep that zeroes one bin per cycle. The busy flag is high for the whole sweep, and commands are dropped while it is high.

Top module: `hist_accum`

## Requirements
- R1: A write command (`rw_i` = 1) sampled while `busy_o` is low and `clear_i` is low adds exactly one to the bin selected by `bin_i`. The value of `bin_i` itself is never stored, and no other bin changes.
- R2: A read command (`rw_i` = 0) sampled while `busy_o` is low and `clear_i` is low makes `rd_valid_o` high in the following cycle. In that cycle `rd_count_o` shows the selected bin's count, including every write accepted before the read.
- R3: In the cycle after a write command, or after any command that was not accepted, `rd_valid_o` is low.
- R4: Writes to the same bin in consecutive cycles are each counted. N back-to-back writes raise the bin by N, up to the saturation limit.
- R5: A read accepted in the cycle right after a write to the same bin returns the count that already includes that write.
- R6: A bin holding 2^N-1 keeps that value on further writes and never wraps to zero.
- R7: When `clear_i` is sampled high while `busy_o` is low, `busy_o` is high for exactly 2^M cycles starting in the next cycle. After that, every bin reads zero.
- R8: While `busy_o` is high, every command and every `clear_i` pulse is ignored. A command sampled in the same cycle as an accepted `clear_i` is also ignored.
- R9: While `rst_n` is low, `busy_o` is high and `rd_valid_o` is low. After `rst_n` goes high, `busy_o` stays high for 2^M-1 more cycles, and then every bin reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; starts a zeroing sweep |
| clear_i | input | 1 | Request to zero all bins |
| rw_i | input | 1 | Command select: 1 = increment bin, 0 = read bin |
| bin_i | input | M | Bin number addressed by this cycle's command |
| busy_o | output | 1 | High while the zeroing sweep runs; commands are dropped |
| rd_valid_o | output | 1 | High in the cycle after an accepted read |
| rd_count_o | output | N | Count of the bin read, meaningful when `rd_valid_o` is high |

## Verification
The assertions assume one thing: the clear sweep and the update pipeline never write memory in the same cycle. This holds as long as a command is only accepted while the block is idle and not clearing, which the RTL enforces at the block's edge and not the environment. They also assume that forwarding only ever bridges a write to the command directly behind it. The stimulus keeps inputs free on every cycle, including during sweeps. It drives them on the falling clock edge, steers half of the random addresses into a small group of bins so that same-bin hazards happen often, and uses small M and N so that saturation and full sweeps are reached within the run.

// File: rtl/hist_pkg.sv
// Shared definitions for the histogram accumulator.
// Assumes: the command bit is 1 for an increment and 0 for a read.
package hist_pkg;
    typedef enum logic {
        CMD_READ  = 1'b0,
        CMD_WRITE = 1'b1
    } cmd_e;
endpackage

// File: rtl/hist_bin_ram.sv
// Bin storage: one synchronous read port and one write port.
// Assumes: a read and a write to the same word at one edge return the old
// word; the update stage covers that case by forwarding.
module hist_bin_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store a word when enabled and register the addressed word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/hist_sweep.sv
// Clear sequencer: walks every bin address once, writing zero, and flags busy.
// Assumes: reset or an idle clear request starts a sweep at address zero;
// requests during a sweep are dropped.
module hist_sweep #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    output logic          busy_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    // Advance the sweep address and end the sweep after the last bin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b1;
            addr_o <= '0;
        end else if (busy_o) begin
            addr_o <= addr_o + 1'b1;
            if (addr_o == LAST) begin
                busy_o <= 1'b0;
            end
        end else if (clear_i) begin
            busy_o <= 1'b1;
            addr_o <= '0;
        end
    end

    assign we_o = busy_o;

    AST_SWEEP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> addr_o == '0); // R7
    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && $past(rst_n)) |-> addr_o == AW'($past(addr_o) + 1'b1)); // R7
endmodule

// File: rtl/hist_update.sv
// Increment pipeline. Stage 1 holds the accepted command while memory is read.
// Stage 2 picks the memory word or a forwarded count, adds one with
// saturation, and either writes it back or presents it as read data.
// Assumes: memory read data is registered and arrives with stage 1.
module hist_update #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] mem_q_i,
    output logic          we_o,
    output logic [AW-1:0] wa_o,
    output logic [DW-1:0] wd_o,
    output logic          rd_valid_o,
    output logic [DW-1:0] rd_data_o
);
    localparam logic [DW-1:0] MAXV = {DW{1'b1}};

    logic          s1_vld;
    logic          s1_wr;
    logic [AW-1:0] s1_addr;
    logic          s1_byp;
    logic [DW-1:0] s1_byp_val;
    logic [DW-1:0] cur;
    logic [DW-1:0] nxt;

    // Pick the freshest count and form its saturated successor.
    always_comb begin
        cur = s1_byp ? s1_byp_val : mem_q_i;
        nxt = (cur == MAXV) ? cur : cur + 1'b1;
    end

    assign we_o       = s1_vld & s1_wr;
    assign wa_o       = s1_addr;
    assign wd_o       = nxt;
    assign rd_valid_o = s1_vld & ~s1_wr;
    assign rd_data_o  = cur;

    // Capture the command and note when its bin is being written this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld     <= 1'b0;
            s1_wr      <= 1'b0;
            s1_addr    <= '0;
            s1_byp     <= 1'b0;
            s1_byp_val <= '0;
        end else begin
            s1_vld     <= take_i;
            s1_wr      <= wr_i;
            s1_addr    <= addr_i;
            s1_byp     <= take_i && we_o && (s1_addr == addr_i);
            s1_byp_val <= nxt;
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> wd_o != '0); // R6
    AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(take_i && !wr_i)); // R2
    AST_BYPASS_SAME_BIN: assert property (@(posedge clk) disable iff (!rst_n)
        s1_byp |-> ($past(we_o) && $past(wa_o) == wa_o)); // R4
endmodule

// File: rtl/hist_accum.sv
// Histogram accumulator top: accepts one read or increment command per cycle
// while idle, and zeroes all bins on reset or on a clear request.
// Assumes: inputs are synchronous to clk; commands while busy are dropped.
module hist_accum
    import hist_pkg::*;
#(
    parameter int M = 8,
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         rw_i,
    input  logic [M-1:0] bin_i,
    output logic         busy_o,
    output logic         rd_valid_o,
    output logic [N-1:0] rd_count_o
);
    logic         take;
    logic         is_wr;
    logic         sw_we;
    logic [M-1:0] sw_addr;
    logic         up_we;
    logic [M-1:0] up_addr;
    logic [N-1:0] up_data;
    logic         ram_we;
    logic [M-1:0] ram_wa;
    logic [N-1:0] ram_wd;
    logic [N-1:0] ram_q;

    // Accept a command only when idle and not starting a clear.
    always_comb begin
        take  = !busy_o && !clear_i;
        is_wr = (cmd_e'(rw_i) == CMD_WRITE);
    end

    // Give the memory write port to the sweep or to the update stage.
    always_comb begin
        ram_we = sw_we | up_we;
        ram_wa = sw_we ? sw_addr : up_addr;
        ram_wd = sw_we ? '0 : up_data;
    end

    hist_sweep #(.AW(M)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .busy_o  (busy_o),
        .we_o    (sw_we),
        .addr_o  (sw_addr)
    );

    hist_bin_ram #(.AW(M), .DW(N)) u_ram (
        .clk     (clk),
        .rd_addr (bin_i),
        .rd_data (ram_q),
        .we      (ram_we),
        .wr_addr (ram_wa),
        .wr_data (ram_wd)
    );

    hist_update #(.AW(M), .DW(N)) u_update (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .wr_i       (is_wr),
        .addr_i     (bin_i),
        .mem_q_i    (ram_q),
        .we_o       (up_we),
        .wa_o       (up_addr),
        .wd_o       (up_data),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_count_o)
    );

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_we && up_we)); // R8
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !rd_valid_o); // R8
    AST_RESET_BUSY: assert property (@(posedge clk)
        $past(!rst_n) |-> busy_o); // R9
endmodule

// File: tb/hist_accum_test.sv
`timescale 1ns/1ps
module hist_accum_test;
    localparam int TM   = 5;
    localparam int TN   = 6;
    localparam int NB   = 1 << TM;
    localparam int MAXC = (1 << TN) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_i = 1'b0;
    logic          rw_i = 1'b0;
    logic [TM-1:0] bin_i = '0;
    logic          busy_o;
    logic          rd_valid_o;
    logic [TN-1:0] rd_count_o;

    always #5 clk = ~clk;

    hist_accum #(.M(TM), .N(TN)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .rw_i       (rw_i),
        .bin_i      (bin_i),
        .busy_o     (busy_o),
        .rd_valid_o (rd_valid_o),
        .rd_count_o (rd_count_o)
    );

    int    model [NB];
    int    busy_left = 0;
    bit    exp_vld = 0;
    int    exp_data = 0;
    string exp_req = "R2";
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int bump(input int v);
        return (v >= MAXC) ? MAXC : v + 1;
    endfunction

    // One cycle: check what the previous command produced, then drive a new one.
    task automatic issue(input bit w, input int a, input bit clr, input string req);
        @(negedge clk);
        chk(busy_o == (busy_left > 0), "R7 busy", int'(busy_o), int'(busy_left > 0));
        chk(rd_valid_o == exp_vld, exp_vld ? exp_req : "R3", int'(rd_valid_o), int'(exp_vld));
        if (exp_vld && rd_valid_o) begin
            chk(int'(rd_count_o) == exp_data, exp_req, int'(rd_count_o), exp_data);
        end
        if (busy_left > 0) begin
            busy_left--;
            exp_vld = 0;
        end else if (clr) begin
            busy_left = NB;
            for (int i = 0; i < NB; i++) model[i] = 0;
            exp_vld = 0;
        end else if (w) begin
            model[a] = bump(model[a]);
            exp_vld = 0;
        end else begin
            exp_vld  = 1;
            exp_data = model[a];
            exp_req  = req;
        end
        rw_i    = w;
        bin_i   = a[TM-1:0];
        clear_i = clr;
    endtask

    task automatic wait_idle(input string req);
        while (busy_left > 0) issue(1'b1, 3, 1'b1, req);
    endtask

    initial begin
        int a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB; i++) model[i] = 0;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b1, "R9 busy in reset", int'(busy_o), 1);
        chk(rd_valid_o == 1'b0, "R9 valid in reset", int'(rd_valid_o), 0);
        rst_n = 1'b1;
        busy_left = NB - 1;
        wait_idle("R8");
        // R9: every bin zero after the reset sweep
        for (int i = 0; i < NB; i++) issue(1'b0, i, 1'b0, "R9");
        // R4, R5: back-to-back writes then an immediate read
        issue(1'b1, 2, 1'b0, "R4");
        issue(1'b1, 2, 1'b0, "R4");
        issue(1'b1, 2, 1'b0, "R4");
        issue(1'b0, 2, 1'b0, "R4");
        // R5: alternating write and read on one bin
        for (int i = 0; i < 4; i++) begin
            issue(1'b1, 5, 1'b0, "R5");
            issue(1'b0, 5, 1'b0, "R5");
        end
        // R1: neighbours untouched, value not stored
        issue(1'b0, 4, 1'b0, "R1");
        issue(1'b0, 6, 1'b0, "R1");
        // R6: saturation
        for (int i = 0; i < MAXC + 6; i++) issue(1'b1, 7, 1'b0, "R6");
        issue(1'b0, 7, 1'b0, "R6");
        issue(1'b1, 7, 1'b0, "R6");
        issue(1'b0, 7, 1'b0, "R6");
        // R7, R8: clear with a same-cycle write, writes and clears while busy
        issue(1'b1, 2, 1'b1, "R8");
        for (int i = 0; i < NB + 2; i++) issue(i[0], i % NB, i[1], "R8");
        wait_idle("R8");
        for (int i = 0; i < NB; i++) issue(1'b0, i, 1'b0, "R7");
        // R1, R2, R4: constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            a = (($urandom % 2) == 0) ? int'($urandom % 3) : int'($urandom % NB);
            issue(1'($urandom % 2), a, ($urandom % 400) == 0, "R2");
        end
        wait_idle("R8");
        for (int i = 0; i < NB; i++) issue(1'b0, i, 1'b0, "R1");
        issue(1'b0, 0, 1'b0, "R2");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R2 actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule